// File: doc/BRIEF.md
# Eight-Register Multicycle Processor Core

This block is a small processor that executes a seven-operation instruction set from a single word-addressed memory that holds both code and data. It has eight 32-bit general registers, and each 25-bit instruction sits in the low bits of a 32-bit memory word. Instructions are executed one at a time by a multicycle state machine. Every instruction passes through FETCH, DECODE and EXEC. A load spends one more cycle in LOAD. A halt parks the machine in HALT.

The memory sits outside the block and is synchronous: an address presented in one cycle returns its word on the read-data input in the next cycle, and a write takes effect at the clock edge that ends the cycle in which the write enable is high. The core drives the address, write data and write enable every cycle. It raises `halted` once a halt instruction has executed.

State transitions:
- FETCH always goes to DECODE.
- DECODE always goes to EXEC.
- EXEC goes to LOAD for a load, to HALT for a halt, and to FETCH otherwise.
- LOAD goes to FETCH.
- HALT stays in HALT until reset.

Top module: `mc8_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `halted` low, `mem_we` low and `mem_addr` equal to 0. The registers and the program counter are cleared, so execution starts at address 0.
- R2: The fields of an instruction sit at fixed bit positions:
  - bits 24..22 hold the operation code;
  - bits 21..19 hold the first source register (A);
  - bits 18..16 hold the second register (B);
  - bits 2..0 hold the destination of a register-register operation;
  - bits 15..0 hold a two's-complement offset, sign-extended before any arithmetic.
  Bits 31..25 of the fetched word are ignored.
- R3: Code 0 (add) writes A+B, modulo 2^32, into the destination register.
- R4: Code 1 (nand) writes the bitwise inverse of A AND B into the destination register.
- R5: Code 2 (load) writes memory[A+offset] into register B. The address is taken modulo the memory depth.
- R6: Code 3 (store) writes register B to memory[A+offset] for exactly one cycle.
- R7: Code 4 (branch-if-equal) sets the program counter to PC+1+offset when A equals B, and to PC+1 otherwise. Negative offsets branch backwards.
- R8: Codes 7 (noop) and 5 (spare) change nothing except advancing the program counter by one.
- R9: Code 6 (halt) raises `halted` three cycles after its fetch begins. `halted` then stays high until reset, and `mem_we` never rises again.
- R10: Every instruction takes three cycles, and a load takes four. `mem_we` is never high in two consecutive cycles.
- R11: The countdown program must finish with register 1 equal to 0 and register 2 equal to 0xFFFFFFFF, both stored out to memory, in 59 cycles. The program loads 5 and -1, adds -1 to the counter until it is zero, stores both registers and halts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | ADDR_W (8) | Word address to the unified memory |
| mem_wdata | output | 32 | Data for a store |
| mem_we | output | 1 | Store strobe, one cycle per store |
| mem_rdata | input | 32 | Word read at the address of the previous cycle |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The hardest situation to reach from the ports is a taken branch whose two operands were just produced by a mixture of loads, adds and nands. Such a branch redirects a program whose later register values, and therefore whose stores, depend on the branch. The stimulus builds random programs from a fixed seed that interleave arithmetic, loads, stores, forward branches on random register pairs, and both no-effect codes, with random junk in the ignored upper bits. A reference interpreter in the bench runs each image to predict the final memory and the exact cycle count. Directed programs add a backward-branch countdown loop and a hand-checked nand result.

// File: rtl/mc8_pkg.sv
package mc8_pkg;

    localparam int INSTR_W = 25;
    localparam int REG_IDX_W = 3;
    localparam int NUM_REGS = 1 << REG_IDX_W;
    localparam int OFF_W = 16;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_NAND  = 3'd1,
        OP_LOAD  = 3'd2,
        OP_STORE = 3'd3,
        OP_BEQ   = 3'd4,
        OP_SPARE = 3'd5,
        OP_HALT  = 3'd6,
        OP_NOOP  = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_LOAD   = 3'd3,
        ST_HALT   = 3'd4
    } cpu_state_e;

    typedef struct packed {
        opcode_e                op;
        logic [REG_IDX_W-1:0]   src_a;
        logic [REG_IDX_W-1:0]   src_b;
        logic [OFF_W-1:0]       imm;
    } instr_t;

endpackage

// File: rtl/mc8_regfile.sv
module mc8_regfile
    import mc8_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]      wr_val,
    input  logic [REG_IDX_W-1:0] rd_a_idx,
    input  logic [REG_IDX_W-1:0] rd_b_idx,
    output logic [XLEN-1:0]      rd_a_val,
    output logic [XLEN-1:0]      rd_b_val
);

    logic [XLEN-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_idx == REG_IDX_W'(g))) begin
                regs[g] <= wr_val;
            end
        end
    end

    assign rd_a_val = regs[rd_a_idx];
    assign rd_b_val = regs[rd_b_idx];

endmodule

// File: rtl/mc8_alu.sv
module mc8_alu
    import mc8_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  opnd_a,
    input  logic [XLEN-1:0]  opnd_b,
    input  logic [OFF_W-1:0] imm,
    output logic [XLEN-1:0]  sum,
    output logic [XLEN-1:0]  nand_val,
    output logic [XLEN-1:0]  eff_addr,
    output logic             equal
);

    logic [XLEN-1:0] imm_sext;

    always_comb begin
        imm_sext = {{(XLEN-OFF_W){imm[OFF_W-1]}}, imm};
        sum      = opnd_a + opnd_b;
        nand_val = ~(opnd_a & opnd_b);
        eff_addr = opnd_a + imm_sext;
        equal    = (opnd_a == opnd_b);
    end

endmodule

// File: rtl/mc8_ctrl.sv
module mc8_ctrl
    import mc8_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int XLEN   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [XLEN-1:0]      mem_rdata,
    input  logic [XLEN-1:0]      reg_b_val,
    input  logic [XLEN-1:0]      alu_sum,
    input  logic [XLEN-1:0]      alu_nand,
    input  logic [XLEN-1:0]      alu_ea,
    input  logic                 alu_eq,
    output instr_t               ir,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_we,
    output logic [XLEN-1:0]      mem_wdata,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_widx,
    output logic [XLEN-1:0]      rf_wval,
    output logic                 halted
);

    cpu_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pc_q, pc_d;
    instr_t            ir_q;
    logic [ADDR_W-1:0] pc_inc;
    logic [XLEN-1:0]   imm_sext;
    logic [XLEN-1:0]   br_full;
    logic              unused_hi_bits;

    assign ir = ir_q;

    always_comb begin
        pc_inc   = pc_q + ADDR_W'(1);
        imm_sext = {{(XLEN-OFF_W){ir_q.imm[OFF_W-1]}}, ir_q.imm};
        br_full  = {{(XLEN-ADDR_W){1'b0}}, pc_inc} + imm_sext;
    end

    assign unused_hi_bits = ^{mem_rdata[XLEN-1:INSTR_W],
                              alu_ea[XLEN-1:ADDR_W],
                              br_full[XLEN-1:ADDR_W]};

    // State register, program counter and instruction register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            ir_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            if (state_q == ST_DECODE) begin
                ir_q <= instr_t'(mem_rdata[INSTR_W-1:0]);
            end
        end
    end

    // Next state and next program counter
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = ST_EXEC;
            ST_EXEC: begin
                unique case (ir_q.op)
                    OP_LOAD: state_d = ST_LOAD;
                    OP_HALT: state_d = ST_HALT;
                    OP_BEQ: begin
                        state_d = ST_FETCH;
                        pc_d    = alu_eq ? br_full[ADDR_W-1:0] : pc_inc;
                    end
                    default: begin
                        state_d = ST_FETCH;
                        pc_d    = pc_inc;
                    end
                endcase
            end
            ST_LOAD: begin
                state_d = ST_FETCH;
                pc_d    = pc_inc;
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_FETCH;
        endcase
    end

    // Outputs to memory and register file
    always_comb begin
        mem_addr  = pc_q;
        mem_we    = 1'b0;
        mem_wdata = reg_b_val;
        rf_we     = 1'b0;
        rf_widx   = ir_q.imm[REG_IDX_W-1:0];
        rf_wval   = alu_sum;
        halted    = 1'b0;
        unique case (state_q)
            ST_FETCH, ST_DECODE: ;
            ST_EXEC: begin
                unique case (ir_q.op)
                    OP_ADD: rf_we = 1'b1;
                    OP_NAND: begin
                        rf_we   = 1'b1;
                        rf_wval = alu_nand;
                    end
                    OP_LOAD: mem_addr = alu_ea[ADDR_W-1:0];
                    OP_STORE: begin
                        mem_addr = alu_ea[ADDR_W-1:0];
                        mem_we   = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_LOAD: begin
                rf_we   = 1'b1;
                rf_widx = ir_q.src_b;
                rf_wval = mem_rdata;
            end
            ST_HALT: halted = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mc8_core.sv
module mc8_core
    import mc8_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int XLEN   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              mem_we,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              halted
);

    instr_t               ir;
    logic [XLEN-1:0]      ra_val, rb_val;
    logic [XLEN-1:0]      alu_sum, alu_nand, alu_ea;
    logic                 alu_eq;
    logic                 rf_we;
    logic [REG_IDX_W-1:0] rf_widx;
    logic [XLEN-1:0]      rf_wval;

    mc8_regfile #(.XLEN(XLEN)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rf_we),
        .wr_idx   (rf_widx),
        .wr_val   (rf_wval),
        .rd_a_idx (ir.src_a),
        .rd_b_idx (ir.src_b),
        .rd_a_val (ra_val),
        .rd_b_val (rb_val)
    );

    mc8_alu #(.XLEN(XLEN)) u_alu (
        .opnd_a   (ra_val),
        .opnd_b   (rb_val),
        .imm      (ir.imm),
        .sum      (alu_sum),
        .nand_val (alu_nand),
        .eff_addr (alu_ea),
        .equal    (alu_eq)
    );

    mc8_ctrl #(.ADDR_W(ADDR_W), .XLEN(XLEN)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rdata (mem_rdata),
        .reg_b_val (rb_val),
        .alu_sum   (alu_sum),
        .alu_nand  (alu_nand),
        .alu_ea    (alu_ea),
        .alu_eq    (alu_eq),
        .ir        (ir),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .rf_we     (rf_we),
        .rf_widx   (rf_widx),
        .rf_wval   (rf_wval),
        .halted    (halted)
    );

endmodule

// File: rtl/mc8_core_chk.sv
module mc8_core_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              halted
);

    // R1: a reset edge leaves the core idle and fetching from address 0
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!halted && !mem_we && mem_addr == '0));

    // R9: halted is sticky until reset
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R9: no store once halted
    a_r9_no_store_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R10: a store strobe lasts a single cycle
    a_r10_store_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R6: a store is followed by a fetch, never by the halt state
    a_r6_store_then_run: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !halted);

endmodule

bind mc8_core mc8_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .halted   (halted)
);

// File: tb/sim_mc8_core.sv
module sim_mc8_core;

    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_we;
    logic [31:0]   mem_rdata;
    logic          halted;

    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;

    logic [31:0] mem [DEPTH];
    logic [31:0] img [DEPTH];
    logic [31:0] shadow [DEPTH];

    int errors = 0;
    int checks = 0;
    int halted_writes = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mc8_core #(.ADDR_W(AW), .XLEN(32)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    // Synchronous memory with a preload port used while the core is in reset
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    always @(negedge clk) begin
        if (rst_n && halted && mem_we) halted_writes++;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input int op, input int a, input int b, input int off);
        logic [31:0] w;
        w = '0;
        w[24:22] = 3'(op);
        w[21:19] = 3'(a);
        w[18:16] = 3'(b);
        w[15:0]  = 16'(off);
        return w;
    endfunction

    function automatic logic [31:0] junk();
        logic [31:0] j;
        j = '0;
        j[31:25] = 7'($urandom);
        return j;
    endfunction

    // Reference interpreter built from the requirements
    task automatic model_run(output int cycles);
        logic [31:0] r [8];
        logic [AW-1:0] pc;
        logic [31:0] w, sx, ea;
        int steps;
        for (int k = 0; k < 8; k++) r[k] = '0;
        for (int k = 0; k < DEPTH; k++) shadow[k] = img[k];
        pc = '0;
        cycles = 0;
        steps = 0;
        while (steps < 4000) begin
            w = shadow[pc];
            sx = {{16{w[15]}}, w[15:0]};
            ea = r[w[21:19]] + sx;
            cycles += 3;
            steps++;
            case (w[24:22])
                3'd0: begin r[w[2:0]] = r[w[21:19]] + r[w[18:16]]; pc = pc + 1'b1; end
                3'd1: begin r[w[2:0]] = ~(r[w[21:19]] & r[w[18:16]]); pc = pc + 1'b1; end
                3'd2: begin r[w[18:16]] = shadow[ea[AW-1:0]]; cycles += 1; pc = pc + 1'b1; end
                3'd3: begin shadow[ea[AW-1:0]] = r[w[18:16]]; pc = pc + 1'b1; end
                3'd4: pc = (r[w[21:19]] == r[w[18:16]]) ? AW'(pc + 1 + sx[AW-1:0]) : AW'(pc + 1);
                3'd6: break;
                default: pc = pc + 1'b1;
            endcase
        end
    endtask

    task automatic load_and_reset();
        rst_n = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            ld_en = 1'b1;
            ld_addr = AW'(k);
            ld_data = img[k];
            @(negedge clk);
        end
        ld_en = 1'b0;
        @(negedge clk);
        check("R1", "halted in reset", {31'b0, halted}, 32'd0);
        check("R1", "mem_we in reset", {31'b0, mem_we}, 32'd0);
        check("R1", "fetch address in reset", {24'b0, mem_addr}, 32'd0);
    endtask

    task automatic run_program(input string tag, output int cycles);
        halted_writes = 0;
        rst_n = 1'b1;
        cycles = 0;
        while (!halted && cycles < 5000) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
        end
        if (!halted) begin
            checks++;
            errors++;
            $display("FAIL %s R9 no halt: actual=running expected=halted", tag);
        end
        repeat (12) @(negedge clk);
        check("R9", "halted held", {31'b0, halted}, 32'd1);
        check("R9", "stores after halt", 32'(halted_writes), 32'd0);
    endtask

    task automatic compare_memory(input string req);
        int bad;
        bad = 0;
        for (int k = 0; k < DEPTH; k++) begin
            if (mem[k] !== shadow[k]) begin
                if (bad == 0)
                    $display("FAIL %s memory[%0d]: actual=%h expected=%h", req, k, mem[k], shadow[k]);
                bad++;
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int cyc, mcyc;
        void'($urandom(32'd4242));

        // R11, R7, R5, R3: countdown loop with a backward branch
        for (int k = 0; k < DEPTH; k++) img[k] = '0;
        img[0] = enc(2, 0, 1, 8);
        img[1] = enc(2, 1, 2, 4);
        img[2] = enc(0, 1, 2, 1);
        img[3] = enc(4, 0, 1, 1);
        img[4] = enc(4, 0, 0, -3);
        img[5] = enc(3, 0, 1, 20);
        img[6] = enc(3, 0, 2, 21);
        img[7] = enc(6, 0, 0, 0);
        img[8] = 32'd5;
        img[9] = 32'hFFFF_FFFF;
        load_and_reset();
        run_program("R11", cyc);
        check("R11", "counter register", mem[20], 32'h0000_0000);
        check("R11", "minus-one register", mem[21], 32'hFFFF_FFFF);
        check("R10", "countdown cycles", 32'(cyc), 32'd59);

        // R4, R8, R2: nand with junk upper bits, spare code and noop
        for (int k = 0; k < DEPTH; k++) img[k] = '0;
        img[0] = enc(2, 0, 1, 40);
        img[1] = enc(2, 0, 2, 41);
        img[2] = enc(1, 1, 2, 3) | 32'hFE00_0000;
        img[3] = enc(5, 3, 3, 16'h7FFF) | 32'h5A00_0000;
        img[4] = enc(7, 6, 5, 16'h8003);
        img[5] = enc(3, 0, 3, 30);
        img[6] = enc(3, 2, 1, -1);
        img[7] = enc(6, 0, 0, 0);
        img[40] = 32'hF0F0_1234;
        img[41] = 32'h0000_0030;
        load_and_reset();
        run_program("R4", cyc);
        check("R4", "nand result", mem[30], ~(32'hF0F0_1234 & 32'h0000_0030));
        check("R5", "negative offset store", mem[47], 32'hF0F0_1234);
        check("R8", "noop and spare leave r3", mem[30], 32'hFFFF_FFCF);
        check("R10", "short program cycles", 32'(cyc), 32'd26);

        // R2..R8: random programs against the reference interpreter
        for (int t = 0; t < 24; t++) begin
            int p, n;
            for (int k = 0; k < DEPTH; k++) img[k] = '0;
            for (int k = 200; k < 216; k++) img[k] = $urandom;
            p = 0;
            for (int k = 0; k < 7; k++) img[p++] = enc(2, 7, k, 200 + k) | junk();
            n = 24;
            for (int i = 0; i < n; i++) begin
                int sel, off;
                sel = $urandom % 8;
                case (sel)
                    0, 1: img[p] = enc(0, $urandom % 8, $urandom % 8, $urandom % 7);
                    2:    img[p] = enc(1, $urandom % 8, $urandom % 8, $urandom % 7);
                    3:    img[p] = enc(2, 7, $urandom % 7, 200 + ($urandom % 16));
                    4:    img[p] = enc(3, 7, $urandom % 8, 230 + ($urandom % 8));
                    5: begin
                        off = ((n - 1 - i) >= 2) ? int'($urandom % 3) : 0;
                        img[p] = enc(4, $urandom % 8, $urandom % 8, off);
                    end
                    6:    img[p] = enc(5, $urandom % 8, $urandom % 8, $urandom);
                    default: img[p] = enc(7, $urandom % 8, $urandom % 8, $urandom);
                endcase
                img[p] = img[p] | junk();
                p++;
            end
            for (int k = 0; k < 8; k++) img[p++] = enc(3, 7, k, 220 + k);
            img[p] = enc(6, 0, 0, 0) | junk();
            model_run(mcyc);
            load_and_reset();
            run_program("R3/R4/R5/R6/R7/R8", cyc);
            compare_memory("R3/R4/R5/R6/R7/R8/R2");
            check("R10", "random program cycles", 32'(cyc), 32'(mcyc));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule